// File: doc/BRIEF.md
# Ping-Pong Buffer DMA Channel

This block is one direction of a peripheral DMA path. It moves a stream of beats between a peripheral data port and system memory. A build-time parameter selects the direction. A receive build writes peripheral data into memory. A transmit build reads memory and hands the data to the peripheral. Memory-to-memory copies are not possible, because the peripheral port is always one end of every beat.

Software sets up two buffer descriptors. Each one holds a start address and a byte count. The channel works through the current buffer with an address that only rises and never wraps. When that buffer is used up, the channel marks it done and moves straight to the other descriptor, with no idle cycle in between. The done flag raises an interrupt, which a mask bit gates, so that software can refill the buffer that has just finished. On a receive build, an end-of-packet strobe from the peripheral closes the buffer early. The number of bytes actually moved is kept for software to read. Each beat is one, four or sixteen bytes wide.

Every beat goes through a request/grant handshake with the system bus. The request depends on the peripheral's request and the current descriptor's state, and the beat completes in the cycle the grant is high. If the peripheral asks for service while the current descriptor is empty, the channel raises a sticky starvation flag.

Top module: `ppd_dma_chan`

## Requirements
- R1: After reset, the CTRL (offset 4) and STATUS (offset 5) registers read 0, and `irq` and `bus_req` are low.
- R2: A write to COUNT0 (offset 1) or COUNT1 (offset 3) with a nonzero value sets that descriptor's valid bit (STATUS bit 4 or 5). A zero count leaves the bit clear. While a descriptor is valid, writes to its BASE (offset 0 or 2) and COUNT registers are ignored.
- R3: `bus_req` is high only when `per_req` is high and the current descriptor is valid. A beat happens only in a cycle where `bus_gnt` is high, and with the grant low the address does not move.
- R4: The CTRL beat-size field, bits [2:1], selects the step. Code 0 is 1 byte, code 1 is 4 bytes, and codes 2 and 3 are 16 bytes. Each beat adds the step to the live address, read at BASEn, and takes it from the remaining count, read at COUNTn. The address carries into higher bits and never wraps.
- R5: A buffer is exhausted on a beat that leaves no more than the step remaining. It then becomes invalid, its done flag is set (STATUS bit 0 or 1) and the current-buffer bit (STATUS bit 3) toggles. If the other buffer is valid, the next cycle already carries its first beat.
- R6: When `per_req` is high while the current descriptor is invalid, no request is made and the sticky starvation flag (STATUS bit 2) is set. Writing 1 to that bit clears it.
- R7: `irq` equals CTRL bit 0 AND (done0 OR done1). Writing 1 to a STATUS done bit clears it.
- R8: On a receive build, `per_eop` on a beat closes the current buffer after that beat. XFER0 (offset 6) and XFER1 (offset 7) hold the bytes moved since the last count write. A transmit build ignores `per_eop`.
- R9: A receive build drives `bus_we` high and `bus_wdata` equals `per_din`. A transmit build drives `bus_we` low and `per_dout` equals `bus_rdata`. In both builds, `per_ack` is high exactly on beats.
- R10: A packet that is longer than the first buffer carries on into the second buffer, and each buffer keeps its own byte tally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | 3 | Register offset |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked buffer-done interrupt |
| per_req | input | 1 | Peripheral has data (receive) or wants data (transmit) |
| per_eop | input | 1 | End of packet, used on receive builds only |
| per_din | input | DW | Peripheral data toward memory |
| per_ack | output | 1 | Beat taken or given this cycle |
| per_dout | output | DW | Memory data toward the peripheral |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant; the beat completes when high |
| bus_addr | output | AW | Beat address |
| bus_we | output | 1 | 1 means memory write |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data |

## Verification
The bench builds two copies with AW=32, CW=16 and DW=128: a receive copy (RX=1) and a transmit copy (RX=0). The receive copy carries most of the stimulus. Its beat addresses are checked against a queue of expected addresses, through buffer hand-offs, an early packet end and all three step sizes. With the 32-bit address width, a byte stream can be started at 0xFFFF so that the carry into bit 16 is visible. The transmit copy shows the read-data path and that the packet-end input has no effect there.

// File: rtl/ppd_pkg.sv
// Shared definitions for the ping-pong DMA channel: the beat-size encoding,
// the register offsets and the status bit positions.
// Assumes the software register window is eight words, addressed by 3 bits.
package ppd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_QUAD = 2'd2,
        SZ_WIDE = 2'd3
    } beat_size_e;

    localparam logic [2:0] REG_BASE0 = 3'd0;
    localparam logic [2:0] REG_CNT0  = 3'd1;
    localparam logic [2:0] REG_BASE1 = 3'd2;
    localparam logic [2:0] REG_CNT1  = 3'd3;
    localparam logic [2:0] REG_CTRL  = 3'd4;
    localparam logic [2:0] REG_STAT  = 3'd5;
    localparam logic [2:0] REG_XFER0 = 3'd6;
    localparam logic [2:0] REG_XFER1 = 3'd7;

    localparam int ST_DONE0  = 0;
    localparam int ST_DONE1  = 1;
    localparam int ST_STARVE = 2;
    localparam int ST_CUR    = 3;
    localparam int ST_VALID0 = 4;
    localparam int ST_VALID1 = 5;

    // Bytes moved by one beat of the given size; code 3 behaves as 16.
    function automatic logic [4:0] step_bytes(input beat_size_e s);
        case (s)
            SZ_BYTE: step_bytes = 5'd1;
            SZ_WORD: step_bytes = 5'd4;
            default: step_bytes = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/ppd_desc.sv
// One buffer descriptor: live address, remaining bytes, bytes moved,
// plus the valid and done flags.
// Assumes AW <= 32. Software writes are taken only while the descriptor is
// invalid. A beat is only presented while the descriptor is valid.
module ppd_desc #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_base_i,
    input  logic          wr_count_i,
    input  logic [AW-1:0] base_wdata_i,
    input  logic [CW-1:0] count_wdata_i,
    input  logic          clr_done_i,
    input  logic          beat_i,
    input  logic [4:0]    step_i,
    input  logic          eop_i,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] rem_o,
    output logic [CW-1:0] xfer_o,
    output logic          valid_o,
    output logic          done_o,
    output logic          last_o
);

    localparam logic [CW-1:0] ZERO_CNT = '0;

    // A beat closes the buffer when the count runs out or the packet ends.
    assign last_o = (rem_o <= CW'(step_i)) || eop_i;

    // Address, count and tally: beats advance them, idle writes load them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            rem_o   <= ZERO_CNT;
            xfer_o  <= ZERO_CNT;
            valid_o <= 1'b0;
        end else if (beat_i) begin
            addr_o <= addr_o + AW'(step_i);
            rem_o  <= (rem_o <= CW'(step_i)) ? ZERO_CNT : rem_o - CW'(step_i);
            xfer_o <= xfer_o + CW'(step_i);
            if (last_o) begin
                valid_o <= 1'b0;
            end
        end else if (!valid_o) begin
            if (wr_base_i) begin
                addr_o <= base_wdata_i;
            end
            if (wr_count_i) begin
                rem_o   <= count_wdata_i;
                xfer_o  <= ZERO_CNT;
                valid_o <= (count_wdata_i != ZERO_CNT);
            end
        end
    end

    // Done flag: set on the closing beat, cleared by software write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else if (beat_i && last_o) begin
            done_o <= 1'b1;
        end else if (clr_done_i) begin
            done_o <= 1'b0;
        end
    end

    AST_VALID_DROPS_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(beat_i)); // R5
    AST_DONE_RISES_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(beat_i)); // R5
    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i |=> addr_o == $past(addr_o) + AW'($past(step_i))); // R4
    AST_LOCKED_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !beat_i) |=> ($stable(addr_o) && $stable(rem_o))); // R2

endmodule

// File: rtl/ppd_ctrl.sv
// Channel control: current-buffer pointer, beat-size and interrupt-enable
// register, starvation flag, and the bus request/grant handshake.
// Assumes a beat completes in the same cycle the grant is seen.
module ppd_ctrl
    import ppd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl_i,
    input  logic [2:0] ctrl_wdata_i,
    input  logic       clr_starve_i,
    input  logic       per_req_i,
    input  logic       bus_gnt_i,
    input  logic [1:0] valid_i,
    input  logic [1:0] last_i,
    output logic       cur_o,
    output beat_size_e size_o,
    output logic       irq_en_o,
    output logic       starve_o,
    output logic       bus_req_o,
    output logic       beat_o
);

    // Request only when the peripheral asks and the current buffer is armed.
    assign bus_req_o = per_req_i && valid_i[cur_o];
    assign beat_o    = bus_req_o && bus_gnt_i;

    // Current-buffer pointer: flips on the closing beat of a buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= 1'b0;
        end else if (beat_o && last_i[cur_o]) begin
            cur_o <= ~cur_o;
        end
    end

    // Control register: beat size and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_o   <= SZ_BYTE;
            irq_en_o <= 1'b0;
        end else if (wr_ctrl_i) begin
            size_o   <= beat_size_e'(ctrl_wdata_i[2:1]);
            irq_en_o <= ctrl_wdata_i[0];
        end
    end

    // Sticky starvation flag: a request met an empty current buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            starve_o <= 1'b0;
        end else if (per_req_i && !valid_i[cur_o]) begin
            starve_o <= 1'b1;
        end else if (clr_starve_i) begin
            starve_o <= 1'b0;
        end
    end

    AST_CUR_MOVES_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_o) |-> $past(beat_o)); // R5
    AST_STARVE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(starve_o) |-> ($past(per_req_i) && !$past(bus_req_o))); // R6
    AST_REQ_NEEDS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> per_req_i); // R3

endmodule

// File: rtl/ppd_dma_chan.sv
// One direction of a peripheral DMA channel with two ping-pong descriptors.
// RX=1 writes peripheral data to memory, RX=0 reads memory to the peripheral.
// Assumes AW <= 32 and CW <= 32 so that every field fits a 32-bit register.
module ppd_dma_chan
    import ppd_pkg::*;
#(
    parameter bit RX = 1'b1,
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [2:0]    sw_addr,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata,
    output logic          irq,
    input  logic          per_req,
    input  logic          per_eop,
    input  logic [DW-1:0] per_din,
    output logic          per_ack,
    output logic [DW-1:0] per_dout,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_we,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);

    localparam int NBUF = 2;

    logic [NBUF-1:0][AW-1:0] d_addr;
    logic [NBUF-1:0][CW-1:0] d_rem;
    logic [NBUF-1:0][CW-1:0] d_xfer;
    logic [NBUF-1:0]         d_valid;
    logic [NBUF-1:0]         d_done;
    logic [NBUF-1:0]         d_last;
    logic                    cur;
    beat_size_e              size;
    logic                    irq_en;
    logic                    starve;
    logic                    beat;
    logic [4:0]              step;
    logic                    eop_eff;
    logic                    wr_stat;

    assign step    = step_bytes(size);
    assign eop_eff = RX && per_eop;
    assign wr_stat = sw_we && (sw_addr == REG_STAT);

    // One descriptor per buffer; the offsets are 2*b and 2*b+1.
    for (genvar b = 0; b < NBUF; b++) begin : g_desc
        ppd_desc #(.AW(AW), .CW(CW)) u_desc (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_base_i    (sw_we && (sw_addr == 3'(2*b))),
            .wr_count_i   (sw_we && (sw_addr == 3'(2*b+1))),
            .base_wdata_i (sw_wdata[AW-1:0]),
            .count_wdata_i(sw_wdata[CW-1:0]),
            .clr_done_i   (wr_stat && sw_wdata[ST_DONE0+b]),
            .beat_i       (beat && (cur == 1'(b))),
            .step_i       (step),
            .eop_i        (eop_eff),
            .addr_o       (d_addr[b]),
            .rem_o        (d_rem[b]),
            .xfer_o       (d_xfer[b]),
            .valid_o      (d_valid[b]),
            .done_o       (d_done[b]),
            .last_o       (d_last[b])
        );
    end

    ppd_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (sw_we && (sw_addr == REG_CTRL)),
        .ctrl_wdata_i(sw_wdata[2:0]),
        .clr_starve_i(wr_stat && sw_wdata[ST_STARVE]),
        .per_req_i   (per_req),
        .bus_gnt_i   (bus_gnt),
        .valid_i     (d_valid),
        .last_i      (d_last),
        .cur_o       (cur),
        .size_o      (size),
        .irq_en_o    (irq_en),
        .starve_o    (starve),
        .bus_req_o   (bus_req),
        .beat_o      (beat)
    );

    // Bus and peripheral data paths; the direction is fixed at build time.
    assign bus_addr  = d_addr[cur];
    assign bus_we    = RX;
    assign bus_size  = size;
    assign bus_wdata = per_din;
    assign per_dout  = bus_rdata;
    assign per_ack   = beat;
    assign irq       = irq_en && (|d_done);

    // Register read mux.
    always_comb begin
        case (sw_addr)
            REG_BASE0: sw_rdata = 32'(d_addr[0]);
            REG_CNT0:  sw_rdata = 32'(d_rem[0]);
            REG_BASE1: sw_rdata = 32'(d_addr[1]);
            REG_CNT1:  sw_rdata = 32'(d_rem[1]);
            REG_CTRL:  sw_rdata = {29'd0, size, irq_en};
            REG_STAT:  sw_rdata = {26'd0, d_valid[1], d_valid[0], cur, starve,
                                   d_done[1], d_done[0]};
            REG_XFER0: sw_rdata = 32'(d_xfer[0]);
            default:   sw_rdata = 32'(d_xfer[1]);
        endcase
    end

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(beat) || $past(sw_we))); // R7
    AST_ACK_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (bus_req && bus_gnt)); // R9

endmodule

// File: tb/ppd_dma_chan_bench.sv
// Scoreboard bench: tasks queue the expected beat addresses and a monitor
// on the falling edge pops and compares them as beats appear.
module ppd_dma_chan_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_tx = 1'b0;
    logic         sw_we = 1'b0;
    logic [2:0]   sw_addr = '0;
    logic [31:0]  sw_wdata = '0;
    logic [31:0]  r_rdata, t_rdata;
    logic         r_irq, t_irq;
    logic         per_req = 1'b0, per_eop = 1'b0;
    logic         t_per_req = 1'b0, t_per_eop = 1'b0;
    logic [127:0] per_din = 128'h0123_4567_89ab_cdef_0011_2233_4455_6677;
    logic [127:0] bus_rdata = '0;
    logic         bus_gnt = 1'b0, t_bus_gnt = 1'b0;
    logic         r_ack, t_ack, r_req, t_req, r_we, t_we;
    logic [127:0] r_dout, t_dout, r_wdata, t_wdata;
    logic [31:0]  r_addr, t_addr;
    logic [1:0]   r_size, t_size;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ppd_dma_chan #(.RX(1'b1)) u_ppd_dma_chan (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we && !sel_tx), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(r_rdata), .irq(r_irq),
        .per_req(per_req), .per_eop(per_eop), .per_din(per_din),
        .per_ack(r_ack), .per_dout(r_dout), .bus_req(r_req), .bus_gnt(bus_gnt),
        .bus_addr(r_addr), .bus_we(r_we), .bus_size(r_size),
        .bus_wdata(r_wdata), .bus_rdata(bus_rdata)
    );

    ppd_dma_chan #(.RX(1'b0)) u_ppd_dma_chan_tx (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we && sel_tx), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(t_rdata), .irq(t_irq),
        .per_req(t_per_req), .per_eop(t_per_eop), .per_din(per_din),
        .per_ack(t_ack), .per_dout(t_dout), .bus_req(t_req), .bus_gnt(t_bus_gnt),
        .bus_addr(t_addr), .bus_we(t_we), .bus_size(t_size),
        .bus_wdata(t_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(posedge clk); #1;
        sw_we = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        sw_addr = a;
        #1;
        if (sel_tx) check(t_rdata == exp, tag, t_rdata, exp);
        else        check(r_rdata == exp, tag, r_rdata, exp);
    endtask

    // Drive n granted beats on the receive copy, optional packet end on the last.
    task automatic beats(input int n, input bit eop_last);
        @(posedge clk); #1;
        per_req = 1'b1; bus_gnt = 1'b1;
        for (int i = 0; i < n; i++) begin
            per_eop = eop_last && (i == n-1);
            @(posedge clk); #1;
        end
        per_req = 1'b0; bus_gnt = 1'b0; per_eop = 1'b0;
    endtask

    // Monitor: every receive beat must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && r_req && bus_gnt) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4 unexpected beat actual=%0h expected=none", r_addr);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (r_addr != e || !r_ack) begin
                    n_fail++;
                    $display("FAIL R4 beat address actual=%0h expected=%0h", r_addr, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_reg(3'd4, 32'h0, "R1 ctrl");
        chk_reg(3'd5, 32'h0, "R1 status");
        check(r_irq == 1'b0 && r_req == 1'b0, "R1 irq/req", {r_irq, r_req}, 2'b00);

        // R6 starvation with no descriptor armed
        @(posedge clk); #1 per_req = 1'b1;
        #1 check(r_req == 1'b0, "R6 no request when empty", r_req, 1'b0);
        @(posedge clk); #1 per_req = 1'b0;
        chk_reg(3'd5, 32'h04, "R6 starve set");
        wr(3'd5, 32'h04);
        chk_reg(3'd5, 32'h00, "R6 starve cleared");

        // R2 descriptor arming and write lock
        wr(3'd0, 32'h1000);
        wr(3'd1, 32'h0);
        chk_reg(3'd5, 32'h00, "R2 zero count stays invalid");
        wr(3'd1, 32'd8);
        chk_reg(3'd5, 32'h10, "R2 count arms buffer0");
        wr(3'd0, 32'h2000);
        wr(3'd1, 32'd99);
        chk_reg(3'd0, 32'h1000, "R2 base locked");
        chk_reg(3'd1, 32'd8, "R2 count locked");

        // R5/R8/R10 word beats spanning two buffers, packet ends in buffer1
        wr(3'd4, 32'h3);
        wr(3'd2, 32'h3000);
        wr(3'd3, 32'd32);
        chk_reg(3'd5, 32'h30, "R2 both armed");
        @(posedge clk); #1;
        per_req = 1'b1; bus_gnt = 1'b0;
        #1;
        check(r_req == 1'b1 && r_ack == 1'b0, "R3 request without grant", {r_req, r_ack}, 2'b10);
        check(r_we == 1'b1 && r_wdata == per_din, "R9 receive write path", r_wdata, per_din);
        @(posedge clk); #1;
        check(r_addr == 32'h1000, "R3 address holds without grant", r_addr, 32'h1000);
        per_req = 1'b0;
        exp_q.push_back(32'h1000); exp_q.push_back(32'h1004);
        exp_q.push_back(32'h3000); exp_q.push_back(32'h3004);
        beats(4, 1'b1);
        check(exp_q.size() == 0, "R5 no gap at hand-off", exp_q.size(), 0);
        chk_reg(3'd5, 32'h03, "R5 both done, pointer back to 0");
        check(r_irq == 1'b1, "R7 irq on done", r_irq, 1'b1);
        chk_reg(3'd6, 32'd8, "R10 buffer0 tally");
        chk_reg(3'd7, 32'd8, "R8 early close tally");
        chk_reg(3'd3, 32'd24, "R8 leftover count");

        // R7 mask and clear
        wr(3'd4, 32'h4);
        check(r_irq == 1'b0, "R7 masked", r_irq, 1'b0);
        wr(3'd5, 32'h3);
        chk_reg(3'd5, 32'h00, "R7 done cleared");

        // R4 quad beats
        wr(3'd0, 32'h4000);
        wr(3'd1, 32'd48);
        exp_q.push_back(32'h4000);
        beats(1, 1'b0);
        chk_reg(3'd1, 32'd32, "R4 quad count step");
        chk_reg(3'd0, 32'h4010, "R4 quad address step");
        exp_q.push_back(32'h4010); exp_q.push_back(32'h4020);
        beats(2, 1'b0);
        chk_reg(3'd5, 32'h09, "R5 quad buffer done, pointer 1");
        chk_reg(3'd6, 32'd48, "R4 quad tally");
        check(r_irq == 1'b0, "R7 disabled irq", r_irq, 1'b0);
        wr(3'd4, 32'h5);
        check(r_irq == 1'b1, "R7 enabled irq", r_irq, 1'b1);
        wr(3'd5, 32'h1);
        check(r_irq == 1'b0, "R7 irq after clear", r_irq, 1'b0);

        // R4 byte beats across a 64 KiB boundary, no wrap
        wr(3'd4, 32'h0);
        wr(3'd2, 32'h0000_FFFF);
        wr(3'd3, 32'd3);
        exp_q.push_back(32'h0000_FFFF); exp_q.push_back(32'h0001_0000);
        exp_q.push_back(32'h0001_0001);
        beats(3, 1'b0);
        chk_reg(3'd2, 32'h0001_0002, "R4 byte address carries");
        chk_reg(3'd5, 32'h02, "R5 byte buffer done");

        // R8/R9 transmit copy: read path, packet end ignored
        sel_tx = 1'b1;
        wr(3'd4, 32'h2);
        wr(3'd0, 32'h100);
        wr(3'd1, 32'd8);
        @(posedge clk); #1;
        bus_rdata = 128'hA5A5_0000_FFFF_1234_5678_9ABC_DEF0_0F0F;
        t_per_req = 1'b1; t_bus_gnt = 1'b1; t_per_eop = 1'b1;
        #1;
        check(t_dout == bus_rdata, "R9 transmit read path", t_dout, bus_rdata);
        check(t_we == 1'b0 && t_ack == 1'b1 && t_addr == 32'h100, "R9 transmit beat",
              {t_we, t_ack, t_addr}, {1'b0, 1'b1, 32'h100});
        @(posedge clk); #1;
        t_per_req = 1'b0; t_bus_gnt = 1'b0; t_per_eop = 1'b0;
        chk_reg(3'd1, 32'd4, "R8 transmit count after beat");
        chk_reg(3'd5, 32'h10, "R8 transmit ignores packet end");
        sel_tx = 1'b0;

        check(exp_q.size() == 0, "R4 all expected beats seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule